// File: doc/BRIEF.md
# Region-Position Prefetch Confidence Predictor

This block grades each prefetch request by how likely it is to be useful before the request is sent. Each request arrives with a line address, a code-region identifier and the ordinal position of the request within the stream that its trigger produced. The block records every request in an issued-request table. It keeps, for every resident region and for every stream position inside that region, a pair of outcome counters and a warm-up counter. Outcomes come in on two strobes. A demand hit on a tracked line counts as useful. An eviction of a tracked line that was never used counts as not useful. Either outcome releases the tracking entry.

A query names a region and a position. Three cycles later the block returns a three-level grade and a flag that says whether that slot has seen enough outcomes to be trusted. The two accuracy thresholds are supplied as pairs of small integer weights. Each threshold test is done by scaling the two counts with shifts and adds and then comparing them, so no divider is used. A prefetch engine can use the grade to drop low-grade requests and to send high-grade ones first.

Only one table operation is performed per cycle. A hit takes precedence over an eviction, and an eviction takes precedence over a new request. The surrounding logic presents at most one of these per cycle.

Top module: `pfc_confidence_predictor`

## Requirements
- R1: After reset `g_valid` is low. A query for a region that has never been requested returns grade medium (code 1) with `g_warm` low, because both of its counts are zero.
- R2: A query sampled in cycle c produces `g_valid` high for exactly one cycle, in cycle c+3 and not earlier. The grade codes are: 0 = low, 1 = medium, 2 = high.
- R3: The grade is high when useful·`cfg_hi_useful_wt` > notuseful·`cfg_hi_waste_wt`. With weights 3 and 7 (70 %), counts of 7 useful and 3 not useful stay medium, and 8 useful against 3 not useful grade high.
- R4: When R3 does not apply, the grade is low when useful·`cfg_lo_useful_wt` < notuseful·`cfg_lo_waste_wt`, and medium otherwise. With weights 7 and 3 (30 %), counts of 3 useful and 7 not useful stay medium, and 3 useful against 8 not useful grade low.
- R5: A `use_valid` strobe whose address matches a tracked entry adds one to the useful count of that entry's region and position only. The entry is then freed, so a repeated hit on the same address has no effect.
- R6: An `evict_valid` strobe whose address matches a tracked entry adds one to the not-useful count of that entry's slot and frees the entry. A repeated eviction of the same address has no effect.
- R7: Every counted outcome on a slot advances its warm-up count, which saturates at its maximum. `g_warm` is high when the warm-up count is at least `cfg_warm_limit`.
- R8: An outcome count never reaches all ones. When an increment would take a count to all ones, the slot stores half of the maximum (2^(CW-1)-1) in that count and halves the other count instead.
- R9: When a request names a region that is not resident, the least recently requested region is replaced and all of its slots restart at zero. A region that is requested again becomes the most recent.
- R10: The issued-request table holds 64 entries and writes them in issue order around a ring. The 65th request overwrites the entry of the oldest request, and the other 63 entries stay tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hi_useful_wt | input | TW | Useful weight for the high test |
| cfg_hi_waste_wt | input | TW | Not-useful weight for the high test |
| cfg_lo_useful_wt | input | TW | Useful weight for the low test |
| cfg_lo_waste_wt | input | TW | Not-useful weight for the low test |
| cfg_warm_limit | input | WW | Outcomes needed before a slot is trusted |
| pf_valid | input | 1 | Prefetch request issued |
| pf_addr | input | AW | Line address of the request |
| pf_region | input | RW | Code-region identifier |
| pf_pos | input | POS_W | Position within the stream |
| use_valid | input | 1 | Demand hit on a prefetched line |
| use_addr | input | AW | Address of the hit line |
| evict_valid | input | 1 | Unused prefetched line evicted |
| evict_addr | input | AW | Address of the evicted line |
| q_valid | input | 1 | Confidence query |
| q_region | input | RW | Queried region |
| q_pos | input | POS_W | Queried position |
| g_valid | output | 1 | Grade valid, three cycles after a query |
| g_grade | output | 2 | 0 low, 1 medium, 2 high |
| g_warm | output | 1 | Slot is warmed up |

## Verification
A seeded random mix of requests, hits and evictions over eight regions, with hits and evictions aimed at both live and already-released addresses, is graded against a bench model of the two tables. This separates correct per-slot counting from cross-slot leaks and from double counting. Directed runs then place the counts exactly on each threshold and one step beyond it, which exposes an off-by-one in the strict comparisons. Further directed runs push a count to the halving point, fill the issue ring one entry past its capacity, and cycle through 33 regions with one of them requested again. These show whether halving, ring replacement and least-recent victim choice are each correct.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {
    GRADE_LOW  = 2'd0,
    GRADE_MED  = 2'd1,
    GRADE_HIGH = 2'd2
  } grade_e;
endpackage

// File: rtl/pfc_issue_table.sv
module pfc_issue_table #(
  parameter int ENTRIES = 64,
  parameter int AW      = 16,
  parameter int RW      = 8,
  parameter int POS_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic [AW-1:0]    ins_addr,
  input  logic [RW-1:0]    ins_region,
  input  logic [POS_W-1:0] ins_pos,
  input  logic             lk_valid,
  input  logic [AW-1:0]    lk_addr,
  output logic             lk_found,
  output logic [RW-1:0]    lk_region,
  output logic [POS_W-1:0] lk_pos
);
  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0] v_q, v_d, match;
  logic [AW-1:0]      a_q [ENTRIES];
  logic [RW-1:0]      r_q [ENTRIES];
  logic [POS_W-1:0]   p_q [ENTRIES];
  logic [IW-1:0]      wp_q, wp_d, hit_idx;

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      match[i] = v_q[i] && (a_q[i] == lk_addr);
      if (match[i]) hit_idx = IW'(i);
    end
  end

  assign lk_found  = |match;
  assign lk_region = r_q[hit_idx];
  assign lk_pos    = p_q[hit_idx];

  always_comb begin
    v_d  = v_q;
    wp_d = wp_q;
    if (lk_valid && lk_found) v_d[hit_idx] = 1'b0;
    if (ins_valid) begin
      v_d[wp_q] = 1'b1;
      wp_d      = (wp_q == IW'(ENTRIES - 1)) ? '0 : wp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= '0;
      wp_q <= '0;
    end else begin
      v_q  <= v_d;
      wp_q <= wp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_valid) begin
      a_q[wp_q] <= ins_addr;
      r_q[wp_q] <= ins_region;
      p_q[wp_q] <= ins_pos;
    end
  end

  // R10: the ring must never take an insert and a lookup in the same cycle
  a_r10_single_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_valid && lk_valid));
endmodule

// File: rtl/pfc_region_table.sv
module pfc_region_table #(
  parameter int REGIONS = 32,
  parameter int POS_W   = 2,
  parameter int RW      = 8,
  parameter int CW      = 6,
  parameter int WW      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic [RW-1:0]    alloc_region,
  input  logic             upd_valid,
  input  logic [RW-1:0]    upd_region,
  input  logic [POS_W-1:0] upd_pos,
  input  logic             upd_useful,
  input  logic [RW-1:0]    rd_region,
  input  logic [POS_W-1:0] rd_pos,
  output logic [CW-1:0]    rd_u,
  output logic [CW-1:0]    rd_n,
  output logic [WW-1:0]    rd_w
);
  localparam int RKW = $clog2(REGIONS);
  localparam int POSITIONS = 1 << POS_W;
  localparam logic [CW-1:0] CMAX = '1;

  logic [RW-1:0]      id_q   [REGIONS];
  logic [REGIONS-1:0] val_q, val_d;
  logic [RKW-1:0]     rank_q [REGIONS];
  logic [RKW-1:0]     rank_d [REGIONS];
  logic [CW-1:0]      u_q [REGIONS][POSITIONS];
  logic [CW-1:0]      u_d [REGIONS][POSITIONS];
  logic [CW-1:0]      n_q [REGIONS][POSITIONS];
  logic [CW-1:0]      n_d [REGIONS][POSITIONS];
  logic [WW-1:0]      w_q [REGIONS][POSITIONS];
  logic [WW-1:0]      w_d [REGIONS][POSITIONS];
  logic [REGIONS-1:0] m_alloc, m_upd, m_rd, is_lru;
  logic [RKW-1:0]     tgt, ui, ri;

  function automatic logic [RKW-1:0] first_set(input logic [REGIONS-1:0] v);
    logic [RKW-1:0] idx;
    idx = '0;
    for (int i = REGIONS - 1; i >= 0; i--) if (v[i]) idx = RKW'(i);
    return idx;
  endfunction

  always_comb begin
    for (int i = 0; i < REGIONS; i++) begin
      m_alloc[i] = val_q[i] && (id_q[i] == alloc_region);
      m_upd[i]   = val_q[i] && (id_q[i] == upd_region);
      m_rd[i]    = val_q[i] && (id_q[i] == rd_region);
      is_lru[i]  = (rank_q[i] == RKW'(REGIONS - 1));
    end
    tgt = (|m_alloc) ? first_set(m_alloc) : first_set(is_lru);
    ui  = first_set(m_upd);
    ri  = first_set(m_rd);
  end

  assign rd_u = (|m_rd) ? u_q[ri][rd_pos] : '0;
  assign rd_n = (|m_rd) ? n_q[ri][rd_pos] : '0;
  assign rd_w = (|m_rd) ? w_q[ri][rd_pos] : '0;

  always_comb begin
    val_d  = val_q;
    rank_d = rank_q;
    u_d    = u_q;
    n_d    = n_q;
    w_d    = w_q;
    if (alloc_valid) begin
      if (!(|m_alloc)) begin
        val_d[tgt] = 1'b1;
        for (int p = 0; p < POSITIONS; p++) begin
          u_d[tgt][p] = '0;
          n_d[tgt][p] = '0;
          w_d[tgt][p] = '0;
        end
      end
      for (int i = 0; i < REGIONS; i++)
        if (rank_q[i] < rank_q[tgt]) rank_d[i] = rank_q[i] + 1'b1;
      rank_d[tgt] = '0;
    end
    if (upd_valid && (|m_upd)) begin
      if (upd_useful) begin
        if (u_q[ui][upd_pos] == CMAX - 1'b1) begin
          u_d[ui][upd_pos] = CMAX >> 1;
          n_d[ui][upd_pos] = n_q[ui][upd_pos] >> 1;
        end else begin
          u_d[ui][upd_pos] = u_q[ui][upd_pos] + 1'b1;
        end
      end else begin
        if (n_q[ui][upd_pos] == CMAX - 1'b1) begin
          n_d[ui][upd_pos] = CMAX >> 1;
          u_d[ui][upd_pos] = u_q[ui][upd_pos] >> 1;
        end else begin
          n_d[ui][upd_pos] = n_q[ui][upd_pos] + 1'b1;
        end
      end
      if (w_q[ui][upd_pos] != '1) w_d[ui][upd_pos] = w_q[ui][upd_pos] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      for (int i = 0; i < REGIONS; i++) begin
        rank_q[i] <= RKW'(i);
        for (int p = 0; p < POSITIONS; p++) begin
          u_q[i][p] <= '0;
          n_q[i][p] <= '0;
          w_q[i][p] <= '0;
        end
      end
    end else begin
      val_q  <= val_d;
      rank_q <= rank_d;
      u_q    <= u_d;
      n_q    <= n_d;
      w_q    <= w_d;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_valid && !(|m_alloc)) id_q[tgt] <= alloc_region;
  end

  // R9: the recency ranks stay a permutation, so exactly one victim exists
  a_r9_single_victim: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_lru) == 1);

  // R8: no outcome count is ever left at all ones
  always @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < REGIONS; i++)
        for (int p = 0; p < POSITIONS; p++)
          a_r8_no_overflow: assert (u_q[i][p] != CMAX && n_q[i][p] != CMAX);
    end
  end
endmodule

// File: rtl/pfc_grade_pipe.sv
module pfc_grade_pipe
  import pfc_pkg::*;
#(
  parameter int CW = 6,
  parameter int WW = 4,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] in_u,
  input  logic [CW-1:0] in_n,
  input  logic [WW-1:0] in_w,
  input  logic [TW-1:0] hi_u_wt,
  input  logic [TW-1:0] hi_n_wt,
  input  logic [TW-1:0] lo_u_wt,
  input  logic [TW-1:0] lo_n_wt,
  input  logic [WW-1:0] warm_limit,
  output logic          out_valid,
  output grade_e        out_grade,
  output logic          out_warm
);
  localparam int SW = CW + TW;

  function automatic logic [SW-1:0] scale(input logic [CW-1:0] v, input logic [TW-1:0] w);
    logic [SW-1:0] s;
    s = '0;
    for (int b = 0; b < TW; b++) if (w[b]) s = s + (SW'(v) << b);
    return s;
  endfunction

  logic          s1_valid, s2_valid;
  logic [CW-1:0] s1_u, s1_n;
  logic [WW-1:0] s1_w;
  logic [SW-1:0] s2_hu, s2_hn, s2_lu, s2_ln;
  logic          s2_warm;
  grade_e        grade_d;
  logic [1:0]    age_q;

  always_comb begin
    if (s2_hu > s2_hn)      grade_d = GRADE_HIGH;
    else if (s2_lu < s2_ln) grade_d = GRADE_LOW;
    else                    grade_d = GRADE_MED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s2_valid  <= 1'b0;
      out_valid <= 1'b0;
      age_q     <= '0;
    end else begin
      s1_valid  <= in_valid;
      s2_valid  <= s1_valid;
      out_valid <= s2_valid;
      if (age_q != 2'd3) age_q <= age_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_u <= in_u;
      s1_n <= in_n;
      s1_w <= in_w;
    end
    if (s1_valid) begin
      s2_hu   <= scale(s1_u, hi_u_wt);
      s2_hn   <= scale(s1_n, hi_n_wt);
      s2_lu   <= scale(s1_u, lo_u_wt);
      s2_ln   <= scale(s1_n, lo_n_wt);
      s2_warm <= (s1_w >= warm_limit);
    end
    if (s2_valid) begin
      out_grade <= grade_d;
      out_warm  <= s2_warm;
    end
  end

  // R2: one result per query, three cycles later
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R2: only the three defined grade codes appear
  a_r2_grade_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_grade != 2'd3));
endmodule

// File: rtl/pfc_confidence_predictor.sv
module pfc_confidence_predictor
  import pfc_pkg::*;
#(
  parameter int AW            = 16,
  parameter int RW            = 8,
  parameter int POS_W         = 2,
  parameter int ISSUE_ENTRIES = 64,
  parameter int REGIONS       = 32,
  parameter int CW            = 6,
  parameter int WW            = 4,
  parameter int TW            = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    cfg_hi_useful_wt,
  input  logic [TW-1:0]    cfg_hi_waste_wt,
  input  logic [TW-1:0]    cfg_lo_useful_wt,
  input  logic [TW-1:0]    cfg_lo_waste_wt,
  input  logic [WW-1:0]    cfg_warm_limit,
  input  logic             pf_valid,
  input  logic [AW-1:0]    pf_addr,
  input  logic [RW-1:0]    pf_region,
  input  logic [POS_W-1:0] pf_pos,
  input  logic             use_valid,
  input  logic [AW-1:0]    use_addr,
  input  logic             evict_valid,
  input  logic [AW-1:0]    evict_addr,
  input  logic             q_valid,
  input  logic [RW-1:0]    q_region,
  input  logic [POS_W-1:0] q_pos,
  output logic             g_valid,
  output logic [1:0]       g_grade,
  output logic             g_warm
);
  logic             lk_valid, lk_found, ins_valid;
  logic [AW-1:0]    lk_addr;
  logic [RW-1:0]    lk_region;
  logic [POS_W-1:0] lk_pos;
  logic [CW-1:0]    rd_u, rd_n;
  logic [WW-1:0]    rd_w;
  grade_e           grade;

  // one operation per cycle: hit, then eviction, then new request
  assign lk_valid  = use_valid | evict_valid;
  assign lk_addr   = use_valid ? use_addr : evict_addr;
  assign ins_valid = pf_valid & ~lk_valid;

  pfc_issue_table #(
    .ENTRIES(ISSUE_ENTRIES), .AW(AW), .RW(RW), .POS_W(POS_W)
  ) u_issue (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_addr(pf_addr), .ins_region(pf_region), .ins_pos(pf_pos),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_found(lk_found), .lk_region(lk_region), .lk_pos(lk_pos)
  );

  pfc_region_table #(
    .REGIONS(REGIONS), .POS_W(POS_W), .RW(RW), .CW(CW), .WW(WW)
  ) u_regions (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(ins_valid), .alloc_region(pf_region),
    .upd_valid(lk_valid & lk_found), .upd_region(lk_region), .upd_pos(lk_pos),
    .upd_useful(use_valid),
    .rd_region(q_region), .rd_pos(q_pos),
    .rd_u(rd_u), .rd_n(rd_n), .rd_w(rd_w)
  );

  pfc_grade_pipe #(
    .CW(CW), .WW(WW), .TW(TW)
  ) u_grade (
    .clk(clk), .rst_n(rst_n),
    .in_valid(q_valid), .in_u(rd_u), .in_n(rd_n), .in_w(rd_w),
    .hi_u_wt(cfg_hi_useful_wt), .hi_n_wt(cfg_hi_waste_wt),
    .lo_u_wt(cfg_lo_useful_wt), .lo_n_wt(cfg_lo_waste_wt),
    .warm_limit(cfg_warm_limit),
    .out_valid(g_valid), .out_grade(grade), .out_warm(g_warm)
  );

  assign g_grade = grade;
endmodule

// File: tb/pfc_confidence_predictor_test.sv
`timescale 1ns/1ps
module pfc_confidence_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cfg_hi_useful_wt, cfg_hi_waste_wt, cfg_lo_useful_wt, cfg_lo_waste_wt, cfg_warm_limit;
  logic        pf_valid, use_valid, evict_valid, q_valid;
  logic [15:0] pf_addr, use_addr, evict_addr;
  logic [7:0]  pf_region, q_region;
  logic [1:0]  pf_pos, q_pos;
  logic        g_valid, g_warm;
  logic [1:0]  g_grade;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model
  int mu [256][4];
  int mn [256][4];
  int mw [256][4];
  bit mv [64];
  int ma [64];
  int mr [64];
  int mp [64];
  int mwp = 0;
  int issued [$];

  always #2.5 clk = ~clk;

  pfc_confidence_predictor uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_hi_useful_wt(cfg_hi_useful_wt), .cfg_hi_waste_wt(cfg_hi_waste_wt),
    .cfg_lo_useful_wt(cfg_lo_useful_wt), .cfg_lo_waste_wt(cfg_lo_waste_wt),
    .cfg_warm_limit(cfg_warm_limit),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_region(pf_region), .pf_pos(pf_pos),
    .use_valid(use_valid), .use_addr(use_addr),
    .evict_valid(evict_valid), .evict_addr(evict_addr),
    .q_valid(q_valid), .q_region(q_region), .q_pos(q_pos),
    .g_valid(g_valid), .g_grade(g_grade), .g_warm(g_warm)
  );

  function automatic int exp_grade(int u, int n);
    if (u * int'(cfg_hi_useful_wt) > n * int'(cfg_hi_waste_wt)) return 2;
    if (u * int'(cfg_lo_useful_wt) < n * int'(cfg_lo_waste_wt)) return 0;
    return 1;
  endfunction

  task automatic model_outcome(int a, bit useful);
    int idx = -1;
    for (int i = 63; i >= 0; i--) if (mv[i] && ma[i] == a) idx = i;
    if (idx >= 0) begin
      int r = mr[idx];
      int p = mp[idx];
      mv[idx] = 0;
      if (useful) begin
        if (mu[r][p] + 1 == 63) begin mu[r][p] = 31; mn[r][p] = mn[r][p] / 2; end
        else mu[r][p]++;
      end else begin
        if (mn[r][p] + 1 == 63) begin mn[r][p] = 31; mu[r][p] = mu[r][p] / 2; end
        else mn[r][p]++;
      end
      if (mw[r][p] != 15) mw[r][p]++;
    end
  endtask

  task automatic op_req(int a, int r, int p);
    @(negedge clk);
    pf_valid = 1; pf_addr = a[15:0]; pf_region = r[7:0]; pf_pos = p[1:0];
    @(negedge clk);
    pf_valid = 0;
    ma[mwp] = a; mr[mwp] = r; mp[mwp] = p; mv[mwp] = 1;
    mwp = (mwp + 1) % 64;
    issued.push_back(a);
  endtask

  task automatic op_use(int a);
    @(negedge clk);
    use_valid = 1; use_addr = a[15:0];
    @(negedge clk);
    use_valid = 0;
    model_outcome(a, 1);
  endtask

  task automatic op_evict(int a);
    @(negedge clk);
    evict_valid = 1; evict_addr = a[15:0];
    @(negedge clk);
    evict_valid = 0;
    model_outcome(a, 0);
  endtask

  task automatic check_q(int r, int p, int eg, int ew, string tag);
    @(negedge clk);
    q_valid = 1; q_region = r[7:0]; q_pos = p[1:0];
    @(negedge clk);
    q_valid = 0;
    @(negedge clk);
    checks++;
    if (g_valid !== 1'b0) begin
      failures++;
      $display("FAIL %s (R2 early result): g_valid=%0b expected 0", tag, g_valid);
    end
    @(negedge clk);
    checks++;
    if (g_valid !== 1'b1 || g_grade !== eg[1:0] || g_warm !== ew[0]) begin
      failures++;
      $display("FAIL %s: valid=%0b grade=%0d warm=%0b expected valid=1 grade=%0d warm=%0d",
               tag, g_valid, g_grade, g_warm, eg, ew);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0;
    pf_valid = 0; use_valid = 0; evict_valid = 0; q_valid = 0;
    pf_addr = 0; use_addr = 0; evict_addr = 0; pf_region = 0; pf_pos = 0; q_region = 0; q_pos = 0;
    cfg_hi_useful_wt = 4'd3; cfg_hi_waste_wt = 4'd7;
    cfg_lo_useful_wt = 4'd7; cfg_lo_waste_wt = 4'd3;
    cfg_warm_limit = 4'd3;
    for (int r = 0; r < 256; r++) for (int p = 0; p < 4; p++) begin mu[r][p] = 0; mn[r][p] = 0; mw[r][p] = 0; end
    for (int i = 0; i < 64; i++) mv[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (g_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: g_valid=%0b expected 0", g_valid);
    end
    check_q(5, 0, 1, 0, "R1 untracked region");

    // random phase: R3 R4 R5 R6 against the model
    for (int it = 0; it < 300; it++) begin
      int sel = $urandom_range(0, 3);
      if (sel < 2 || issued.size() == 0)
        op_req(16'h1000 + it, 10 + $urandom_range(0, 7), $urandom_range(0, 3));
      else begin
        int a = issued[$urandom_range(0, issued.size() - 1)];
        if (sel == 2) op_use(a); else op_evict(a);
      end
      if (it % 8 == 7) begin
        int r = 10 + $urandom_range(0, 7);
        int p = $urandom_range(0, 3);
        check_q(r, p, exp_grade(mu[r][p], mn[r][p]), (mw[r][p] >= 3) ? 1 : 0, "R3/R4/R5/R6 random");
      end
    end

    // R5: useful count, release of entry, per-position separation
    op_req(16'h8000, 1, 2); op_use(16'h8000);
    check_q(1, 2, 2, 0, "R5 useful hit");
    op_use(16'h8000);
    op_req(16'h8001, 1, 2); op_use(16'h8001);
    check_q(1, 2, 2, 0, "R5 repeated hit ignored");
    check_q(1, 1, 1, 0, "R5 other position untouched");
    // R7: warm-up
    op_req(16'h8002, 1, 2); op_use(16'h8002);
    check_q(1, 2, 2, 1, "R7 warm at limit");
    cfg_warm_limit = 4'd4;
    check_q(1, 2, 2, 0, "R7 raised limit");
    cfg_warm_limit = 4'd3;
    // R6: not-useful count
    op_req(16'h8003, 1, 1); op_evict(16'h8003);
    check_q(1, 1, 0, 0, "R6 eviction counted");
    op_evict(16'h8003);
    op_req(16'h8004, 1, 1); op_evict(16'h8004);
    check_q(1, 1, 0, 0, "R6 repeated eviction ignored");

    // R3 boundary
    for (int i = 0; i < 7; i++) begin op_req(16'h8100 + i, 2, 1); op_use(16'h8100 + i); end
    for (int i = 7; i < 10; i++) begin op_req(16'h8100 + i, 2, 1); op_evict(16'h8100 + i); end
    check_q(2, 1, 1, 1, "R3 exactly 70 percent is medium");
    op_req(16'h810A, 2, 1); op_use(16'h810A);
    check_q(2, 1, 2, 1, "R3 above upper threshold");
    // R4 boundary
    for (int i = 0; i < 3; i++) begin op_req(16'h8120 + i, 2, 2); op_use(16'h8120 + i); end
    for (int i = 3; i < 10; i++) begin op_req(16'h8120 + i, 2, 2); op_evict(16'h8120 + i); end
    check_q(2, 2, 1, 1, "R4 exactly 30 percent is medium");
    op_req(16'h812A, 2, 2); op_evict(16'h812A);
    check_q(2, 2, 0, 1, "R4 below lower threshold");

    // R8: halving at saturation
    for (int i = 0; i < 27; i++) begin op_req(16'h8200 + i, 2, 3); op_evict(16'h8200 + i); end
    for (int i = 27; i < 89; i++) begin op_req(16'h8200 + i, 2, 3); op_use(16'h8200 + i); end
    check_q(2, 3, 1, 1, "R8 before halving 62/27");
    op_req(16'h8300, 2, 3); op_use(16'h8300);
    check_q(2, 3, 2, 1, "R8 halved to 31/13");

    // R10: ring replacement
    for (int i = 0; i < 65; i++) op_req(16'hA000 + i, 3, 3);
    op_use(16'hA000);
    check_q(3, 3, 1, 0, "R10 oldest entry overwritten");
    op_use(16'hA001);
    check_q(3, 3, 2, 0, "R10 next entry still tracked");

    // R9: least recently requested region replaced
    op_req(16'hB000, 100, 0); op_use(16'hB000);
    op_req(16'hB001, 101, 0); op_use(16'hB001);
    for (int r = 102; r < 132; r++) op_req(16'hB000 + r, r, 0);
    op_req(16'hB100, 100, 0);
    op_req(16'hB101, 132, 0);
    check_q(100, 0, 2, 0, "R9 recently requested region kept");
    check_q(101, 0, 1, 0, "R9 least recent region replaced");
    check_q(132, 0, 1, 0, "R9 new region starts cleared");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule